// File: doc/BRIEF.md
# Cascadable Column-Driver Line Capture Latch

This block collects one display line of gray-scale pixel data for a column driver that may be chained with identical drivers. Each clock it can take one group of three 6-bit dots (red, green, blue). Collection of a line opens when the start input chosen by the shift direction is sampled high. The column groups then fill upward in right-shift mode or downward in left-shift mode. Once the last group of the line has been taken, a one-clock start pulse goes out on the opposite side, which lets the next driver in the chain take over.

A latch strobe copies the collected line into an output register that feeds the converter stage. The same strobe samples the drive polarity. Its rising edge also rewinds the fill pointer and switches the outputs off. The outputs are switched on again by the falling edge of an amplifier-phase input, but only after the first strobe since reset has been seen.

All registers use a synchronous active-low reset. Every output is a register, so each effect becomes visible one clock after the edge that sampled its cause.

Top module: `cascade_line_latch`

## Requirements
- R1: While `rst_n` is sampled low, the next clock edge sets `line_out`, `out_en`, `pol_q`, `start_r_out` and `start_l_out` to 0 and rewinds the fill pointer.
- R2: Filling begins on the edge where the selected start input is high: `start_r_in` when `dir_left`=0, `start_l_in` when `dir_left`=1. That edge stores the first group. The start input that is not selected is ignored.
- R3: In right-shift mode (`dir_left`=0), the k-th group taken since the start (k from 0) goes to line values 3k, 3k+1 and 3k+2, fed from `pix_data[5:0]`, `[11:6]` and `[17:12]` in that order. Line value v appears on `line_out[6v+5:6v]`.
- R4: In left-shift mode (`dir_left`=1), the k-th group goes to group slot 79-k, which is line values 3(79-k) to 3(79-k)+2. The dot order inside the group is the same as in R3.
- R5: On the clock after the edge that takes the 80th group, a pulse exactly one clock wide appears on `start_l_out` in right-shift mode or on `start_r_out` in left-shift mode. The other output stays low.
- R6: Once 80 groups have been taken, further data and start pulses change nothing until the next strobe rising edge.
- R7: On each edge where `strobe` is high, `line_out` takes the collected line as it stood before that edge. On every other edge `line_out` holds its value.
- R8: While `strobe` is high, no group is taken. Its rising edge rewinds the pointer, so the next start fills from the first slot again. Slots that are not rewritten keep their old data.
- R9: A rising edge of `strobe` makes `out_en` low on the next cycle.
- R10: A falling edge of `amp_phase` makes `out_en` high on the next cycle, provided a strobe has been seen since reset. While `amp_phase` is sampled high, `out_en` goes low. A strobe rising edge takes priority over an amplifier falling edge in the same cycle.
- R11: Until the first strobe rising edge after reset, `out_en` stays low whatever `amp_phase` does.
- R12: `pol_q` takes `pol_in` on each edge where `strobe` is high and holds it otherwise. A value of 1 means positive polarity and 0 means negative polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_left | input | 1 | 0 = right shift, 1 = left shift |
| start_r_in | input | 1 | Right-side start pulse in (used in right shift) |
| start_l_in | input | 1 | Left-side start pulse in (used in left shift) |
| start_r_out | output | 1 | Right-side cascade pulse out (left shift) |
| start_l_out | output | 1 | Left-side cascade pulse out (right shift) |
| pix_data | input | 18 | Three 6-bit dots: R [5:0], G [11:6], B [17:12] |
| strobe | input | 1 | Latch strobe |
| amp_phase | input | 1 | Amplifier setup phase; falling edge enables drive |
| pol_in | input | 1 | Drive polarity request |
| line_out | output | 1440 | Latched line, 240 values of 6 bits |
| out_en | output | 1 | Output drive enable (0 = high impedance) |
| pol_q | output | 1 | Polarity held for the driven line |

## Verification
Two events can fall in the same cycle: a strobe rising edge and the taking of the 80th group of a line. When they coincide, the strobe wins. No group is stored, no cascade pulse appears, and the line that gets latched is the one as it stood before that edge. The bench brings this about by holding the strobe's rise back until the exact clock that would carry the last group. It then judges the result by a follow-up fill: the absent cascade pulse, and a restart that lands in the first slot. A reference model in the bench, updated every cycle, also compares the outputs while random strobes fall on the edges of random captures.

// File: rtl/srcdrv_pkg.sv
// Package: shared types for the line capture latch.
// Assumes: nothing beyond IEEE 1800-2017.
package srcdrv_pkg;

    // Fill direction of the column groups.
    typedef enum logic {
        SHIFT_RIGHT = 1'b0,
        SHIFT_LEFT  = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/slot_capture_ctrl.sv
// Module: fill pointer, start detection and cascade pulse generation.
// Assumes: strobe_rise is a one-cycle event derived from the strobe input;
// strobe_hi freezes capture.
module slot_capture_ctrl
    import srcdrv_pkg::*;
#(
    parameter  int GROUPS = 80,
    localparam int PTR_W  = $clog2(GROUPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_left,
    input  logic             start_r_in,
    input  logic             start_l_in,
    input  logic             strobe_hi,
    input  logic             strobe_rise,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_slot,
    output logic             casc_r_out,
    output logic             casc_l_out
);

    shift_dir_e       dir;
    logic [PTR_W-1:0] ptr_q;
    logic             active_q;
    logic             full_q;
    logic             start_sel;
    logic             last_take;

    // Decode direction, start selection and write slot.
    always_comb begin
        dir       = shift_dir_e'(dir_left);
        start_sel = (dir == SHIFT_LEFT) ? start_l_in : start_r_in;
        wr_en     = !strobe_hi && !full_q && (active_q || start_sel);
        last_take = wr_en && (ptr_q == PTR_W'(GROUPS - 1));
        wr_slot   = (dir == SHIFT_LEFT) ? (PTR_W'(GROUPS - 1) - ptr_q) : ptr_q;
    end

    // Advance the pointer per taken group; strobe rise rewinds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            active_q <= 1'b0;
            full_q   <= 1'b0;
        end else if (strobe_rise) begin
            ptr_q    <= '0;
            active_q <= 1'b0;
            full_q   <= 1'b0;
        end else if (wr_en) begin
            if (last_take) begin
                ptr_q    <= '0;
                active_q <= 1'b0;
                full_q   <= 1'b1;
            end else begin
                ptr_q    <= ptr_q + 1'b1;
                active_q <= 1'b1;
            end
        end
    end

    // Register the one-clock cascade pulse on the downstream side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            casc_l_out <= 1'b0;
            casc_r_out <= 1'b0;
        end else begin
            casc_l_out <= last_take && (dir == SHIFT_RIGHT);
            casc_r_out <= last_take && (dir == SHIFT_LEFT);
        end
    end

    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < PTR_W'(GROUPS));

    p_casc_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(casc_l_out && casc_r_out));

    p_casc_single_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        casc_l_out |=> !casc_l_out);

    p_casc_single_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
        casc_r_out |=> !casc_r_out);

    p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> !wr_en);

    p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (ptr_q == '0) && !full_q && !active_q);

endmodule

// File: rtl/line_data_store.sv
// Module: per-group capture register and the output line latch.
// Assumes: wr_slot is in range whenever wr_en is high.
module line_data_store #(
    parameter  int GROUPS = 80,
    parameter  int GRP_W  = 18,
    localparam int PTR_W  = $clog2(GROUPS),
    localparam int LINE_W = GROUPS * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [GRP_W-1:0]  wr_data,
    input  logic              strobe_hi,
    output logic [LINE_W-1:0] line_q
);

    logic [LINE_W-1:0] data_flat;

    for (genvar g = 0; g < GROUPS; g++) begin : g_slot
        logic [GRP_W-1:0] slot_q;

        // Store one group when its slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_slot == PTR_W'(g))) begin
                slot_q <= wr_data;
            end
        end

        assign data_flat[g*GRP_W +: GRP_W] = slot_q;
    end

    // Copy the collected line into the output latch on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (strobe_hi) begin
            line_q <= data_flat;
        end
    end

    p_latch_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_hi |=> line_q == $past(data_flat));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_hi |=> $stable(line_q));

endmodule

// File: rtl/drive_phase_seq.sv
// Module: strobe/amplifier edge detection, output enable and polarity hold.
// Assumes: strobe and amp_phase are synchronous to clk.
module drive_phase_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic amp_phase,
    input  logic pol_in,
    output logic strobe_rise,
    output logic out_en,
    output logic pol_q
);

    logic strobe_q;
    logic amp_q;
    logic started_q;
    logic amp_fall;

    // Edge decode from the previous samples.
    always_comb begin
        strobe_rise = strobe && !strobe_q;
        amp_fall    = !amp_phase && amp_q;
    end

    // Keep previous samples and the started flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q  <= 1'b0;
            amp_q     <= 1'b0;
            started_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
            amp_q    <= amp_phase;
            if (strobe_rise) begin
                started_q <= 1'b1;
            end
        end
    end

    // Sequence the drive enable: strobe or setup phase off, amp fall on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en <= 1'b0;
        end else if (strobe_rise || amp_phase) begin
            out_en <= 1'b0;
        end else if (amp_fall && started_q) begin
            out_en <= 1'b1;
        end
    end

    // Sample polarity with the line latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
        end else if (strobe) begin
            pol_q <= pol_in;
        end
    end

    p_off_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> !out_en);

    p_setup_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        amp_phase |=> !out_en);

    p_not_before_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> !out_en);

    p_pol_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(pol_q));

endmodule

// File: rtl/cascade_line_latch.sv
// Module: top of the cascadable line capture latch.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module cascade_line_latch #(
    parameter  int DOT_W       = 6,
    parameter  int DOTS        = 3,
    parameter  int LINE_VALUES = 240,
    localparam int GRP_W       = DOT_W * DOTS,
    localparam int GROUPS      = LINE_VALUES / DOTS,
    localparam int PTR_W       = $clog2(GROUPS),
    localparam int LINE_W      = LINE_VALUES * DOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_left,
    input  logic              start_r_in,
    input  logic              start_l_in,
    output logic              start_r_out,
    output logic              start_l_out,
    input  logic [GRP_W-1:0]  pix_data,
    input  logic              strobe,
    input  logic              amp_phase,
    input  logic              pol_in,
    output logic [LINE_W-1:0] line_out,
    output logic              out_en,
    output logic              pol_q
);

    logic             strobe_rise;
    logic             wr_en;
    logic [PTR_W-1:0] wr_slot;

    drive_phase_seq u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .amp_phase  (amp_phase),
        .pol_in     (pol_in),
        .strobe_rise(strobe_rise),
        .out_en     (out_en),
        .pol_q      (pol_q)
    );

    slot_capture_ctrl #(.GROUPS(GROUPS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_left   (dir_left),
        .start_r_in (start_r_in),
        .start_l_in (start_l_in),
        .strobe_hi  (strobe),
        .strobe_rise(strobe_rise),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .casc_r_out (start_r_out),
        .casc_l_out (start_l_out)
    );

    line_data_store #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_data  (pix_data),
        .strobe_hi(strobe),
        .line_q   (line_out)
    );

endmodule

// File: tb/cascade_line_latch_test.sv
module cascade_line_latch_test;

    localparam int NG = 80;
    localparam int LW = 1440;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dir_left, start_r_in, start_l_in;
    logic            start_r_out, start_l_out;
    logic [17:0]     pix_data;
    logic            strobe, amp_phase, pol_in;
    logic [LW-1:0]   line_out;
    logic            out_en, pol_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    logic [17:0]   m_reg [NG];
    logic [LW-1:0] m_line;
    int            m_ptr;
    bit            m_act, m_full, m_started, m_en, m_pol, m_cl, m_cr, m_sp, m_ap;

    cascade_line_latch uut (
        .clk(clk), .rst_n(rst_n), .dir_left(dir_left),
        .start_r_in(start_r_in), .start_l_in(start_l_in),
        .start_r_out(start_r_out), .start_l_out(start_l_out),
        .pix_data(pix_data), .strobe(strobe), .amp_phase(amp_phase),
        .pol_in(pol_in), .line_out(line_out), .out_en(out_en), .pol_q(pol_q)
    );

    always #5 clk = ~clk;

    function automatic logic [LW-1:0] flat_line();
        logic [LW-1:0] f;
        for (int g = 0; g < NG; g++) f[g*18 +: 18] = m_reg[g];
        return f;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance the model by one edge from the present inputs.
    task automatic model_step();
        bit rise, afall, sel, take, last;
        rise  = strobe && !m_sp;
        afall = !amp_phase && m_ap;
        if (!rst_n) begin
            for (int g = 0; g < NG; g++) m_reg[g] = '0;
            m_line = '0; m_ptr = 0; m_act = 0; m_full = 0; m_started = 0;
            m_en = 0; m_pol = 0; m_cl = 0; m_cr = 0; m_sp = 0; m_ap = 0;
            return;
        end
        last = 0;
        if (strobe) begin
            m_line = flat_line();
            m_pol  = pol_in;
        end
        if (rise || amp_phase) m_en = 0;
        else if (afall && m_started) m_en = 1;
        if (rise) begin
            m_ptr = 0; m_act = 0; m_full = 0; m_started = 1;
        end else if (!strobe) begin
            sel  = dir_left ? start_l_in : start_r_in;
            take = !m_full && (m_act || sel);
            if (take) begin
                m_reg[dir_left ? NG-1-m_ptr : m_ptr] = pix_data;
                if (m_ptr == NG-1) begin
                    last = 1; m_full = 1; m_act = 0; m_ptr = 0;
                end else begin
                    m_ptr++; m_act = 1;
                end
            end
        end
        m_cl = last && !dir_left;
        m_cr = last && dir_left;
        m_sp = strobe;
        m_ap = amp_phase;
    endtask

    // One clock: model, edge, compare one time unit after the edge.
    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        if (line_out !== m_line) begin
            for (int v = 0; v < 240; v++)
                if (line_out[v*6 +: 6] !== m_line[v*6 +: 6]) begin
                    chk(0, $sformatf("R3/R4/R7 line value %0d", v),
                        64'(line_out[v*6 +: 6]), 64'(m_line[v*6 +: 6]));
                    break;
                end
        end else chk(1, "R7", 0, 0);
        chk(out_en === m_en, "R9/R10/R11 out_en", 64'(out_en), 64'(m_en));
        chk(pol_q === m_pol, "R12 pol_q", 64'(pol_q), 64'(m_pol));
        chk(start_l_out === m_cl, "R5 start_l_out", 64'(start_l_out), 64'(m_cl));
        chk(start_r_out === m_cr, "R5 start_r_out", 64'(start_r_out), 64'(m_cr));
        @(negedge clk);
    endtask

    task automatic idle();
        start_r_in = 0; start_l_in = 0; strobe = 0; amp_phase = 0;
        pix_data = 18'($urandom);
    endtask

    // Push n groups with a start on the first one, selected side by dir.
    task automatic fill(input bit dir, input int n);
        dir_left = dir;
        for (int i = 0; i < n; i++) begin
            idle();
            if (i == 0) begin
                if (dir) start_l_in = 1; else start_r_in = 1;
            end
            cyc();
        end
        idle();
    endtask

    task automatic pulse_strobe(input bit p);
        idle(); strobe = 1; pol_in = p; cyc();
        idle(); cyc();
    endtask

    initial begin
        logic [17:0] first_grp;
        void'($urandom(32'd1234));
        rst_n = 0; dir_left = 0; pol_in = 0;
        idle();
        @(negedge clk);
        repeat (3) cyc();
        // R1: reset state
        chk(line_out == '0 && !out_en && !pol_q && !start_r_out && !start_l_out,
            "R1 reset outputs", {59'd0, out_en, pol_q, start_r_out, start_l_out, |line_out}, 0);
        rst_n = 1;
        idle(); cyc();

        // R11: amplifier fall before any strobe leaves output off
        amp_phase = 1; cyc(); cyc();
        idle(); cyc();
        chk(!out_en, "R11 no drive before first strobe", 64'(out_en), 0);

        // R2: unselected start (left pin in right mode) is ignored
        dir_left = 0; start_l_in = 1; pix_data = 18'h3ffff; cyc();
        idle(); cyc();
        pulse_strobe(1);
        chk(line_out == '0, "R2 unselected start ignored", 64'(line_out[63:0]), 0);

        // R3 + R5 + R6: right-shift line
        dir_left = 0; idle(); start_r_in = 1; first_grp = pix_data; cyc();
        fill(0, 0);
        for (int i = 1; i < NG; i++) begin idle(); cyc(); end
        chk(start_l_out && !start_r_out, "R5 cascade on left pin", 64'({start_l_out, start_r_out}), 64'd2);
        idle(); start_r_in = 1; cyc();
        chk(!start_l_out, "R5 pulse one clock wide", 64'(start_l_out), 0);
        repeat (4) begin idle(); cyc(); end  // R6: ignored extra data
        pulse_strobe(1);
        chk(line_out[17:0] == first_grp, "R3 first group at values 0..2",
            64'(line_out[17:0]), 64'(first_grp));
        chk(pol_q == 1'b1, "R12 positive polarity held", 64'(pol_q), 1);

        // R10 + R9: amplifier phase and strobe sequencing
        amp_phase = 1; cyc();
        chk(!out_en, "R10 setup phase off", 64'(out_en), 0);
        amp_phase = 0; cyc();
        chk(out_en, "R10 amp fall enables", 64'(out_en), 1);
        strobe = 1; pol_in = 0; cyc();
        chk(!out_en, "R9 strobe rise disables", 64'(out_en), 0);
        idle(); cyc();

        // R4: left-shift line, first group lands in top slot
        idle(); dir_left = 1; start_l_in = 1; first_grp = pix_data; cyc();
        for (int i = 1; i < NG; i++) begin idle(); cyc(); end
        chk(start_r_out && !start_l_out, "R5 cascade on right pin", 64'({start_r_out, start_l_out}), 64'd2);
        idle(); cyc();
        pulse_strobe(0);
        chk(line_out[LW-1 -: 18] == first_grp, "R4 first group at values 237..239",
            64'(line_out[LW-1 -: 18]), 64'(first_grp));

        // R8: strobe rise in the same cycle as the 80th group
        idle(); dir_left = 0; start_r_in = 1; cyc();
        for (int i = 1; i < NG - 1; i++) begin idle(); cyc(); end
        idle(); strobe = 1; cyc();
        chk(!start_l_out, "R8 no cascade when strobe meets last group", 64'(start_l_out), 0);
        idle(); cyc();
        idle(); start_r_in = 1; first_grp = pix_data; cyc();
        idle(); cyc();
        pulse_strobe(0);
        chk(line_out[17:0] == first_grp, "R8 restart at first slot",
            64'(line_out[17:0]), 64'(first_grp));

        // Random phase: model compares every cycle
        for (int i = 0; i < 6000; i++) begin
            idle();
            dir_left   = ($urandom % 200) == 0 ? ~dir_left : dir_left;
            start_r_in = ($urandom % 40) == 0;
            start_l_in = ($urandom % 40) == 0;
            strobe     = ($urandom % 60) == 0;
            amp_phase  = ($urandom % 8) == 0;
            pol_in     = 1'($urandom);
            cyc();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule